// File: doc/BRIEF.md
# GF(3^97) Unified Add / Multiply / Cube Operator

This block is one processing element for arithmetic in GF(3^97), built as GF(3)[x]/(x^97 + x^12 + 2). Each of the 97 trits takes two bits, so a field element is a 194-bit word. Three partial-product generators, one multi-operand adder and one accumulator register carry out three operations: addition or subtraction with per-operand weights, digit-serial multiplication at three multiplier trits per clock, and cubing.

Three operand registers are loaded from outside. The first is a shift register. For a product it holds the multiplier. For an addition or a cube it holds a small control word whose lowest trits are the weights. The other two hold the remaining operands. A cube can write its result straight back into both operand registers, so a run of cubings needs no reload.

Top module: `gf3m_unified_op`

## Requirements
- R1: While rst_n is low at a rising edge, result is cleared to zero and busy and done are cleared.
- R2: Trits use the encoding 00 = 0, 01 = 1, 10 = 2, with trit i at bits [2i+1:2i]. The code 11 never appears in result.
- R3: Add (op = 0): result = c0·B + c1·A, computed trit by trit mod 3. B is the second-operand register, A is the first-operand register, c0 is trit 0 of the control register and c1 is trit 1. done is high in the cycle after the start edge, and busy stays low.
- R4: Multiply (op = 1): the multiplier a sits in trits 0..96 of the control register, with trits 97 and 98 zero. b sits in both operand registers. result = a·b mod f. busy stays high for 33 cycles, and done pulses in the 33rd cycle after the start edge.
- R5: Products are reduced with x^97 = 2x^12 + 1. For example, x^96 · x^2 gives x + 2x^13.
- R6: Cube (op = 2): a sits in both operand registers, and result = c0·a^3 mod f. So c0 = 1 gives a^3 and c0 = 2 gives −a^3. done follows one cycle after start.
- R7: A cube started with chain = 1 also writes its result into both operand registers at the same edge. A second chained cube therefore returns a^9.
- R8: While busy is high, start, the load strobes and chain have no effect on the running product or on the operand registers.
- R9: op = 3 is reserved. Starting it raises neither done nor busy, and result keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_ctl | input | 1 | Load the control/multiplier shift register from din_ctl |
| ld_opa | input | 1 | Load operand register A from din_opa |
| ld_opb | input | 1 | Load operand register B from din_opb |
| din_ctl | input | 198 | 99 trits: multiplier, or control word in trits 0 and 1 |
| din_opa | input | 194 | Operand A (97 trits) |
| din_opb | input | 194 | Operand B (97 trits) |
| start | input | 1 | Start the operation selected by op |
| op | input | 2 | 0 add, 1 multiply, 2 cube, 3 reserved |
| chain | input | 1 | With a cube, write the result back into A and B |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | 194 | Accumulator contents |

## Verification
A fault in the shift or step counter shows up as done arriving at the wrong cycle, or as a product that uses the wrong trit triple. Both are visible at the first product check, 33 cycles after its start. A wrong reduction tap or a wrong cubing term corrupts every result whose intermediate degree passes 96. A directed product that lands exactly on x^98, together with chained cubes, makes such an error visible at the very next done. A register that changes while a product runs would corrupt that product. The bench also reads the first operand back through a weighted add right after the product completes.

// File: rtl/gf3m_pkg.sv
// Shared constants, types and trit arithmetic for the GF(3^97) operator.
// Assumes trit codes 00/01/10 only; 11 is never generated internally.
package gf3m_pkg;
    parameter int M = 97;              // extension degree
    parameter int K = 12;              // middle exponent of the modulus
    parameter int D = 3;               // multiplier trits per step
    localparam int W     = 2 * M;      // element width in bits
    localparam int STEPS = (M + D - 1) / D;
    localparam int CT    = STEPS * D;  // trits in the control register
    localparam int CW    = 2 * CT;
    localparam int NW    = $clog2(STEPS + 1);

    typedef logic [1:0]   trit_t;
    typedef logic [W-1:0] elem_t;
    typedef enum logic [1:0] {OP_ADD = 2'd0, OP_MUL = 2'd1,
                              OP_CUBE = 2'd2, OP_RSV = 2'd3} op_e;

    function automatic trit_t t_add(trit_t a, trit_t b);
        int s;
        s = (int'(a) + int'(b)) % 3;
        return trit_t'(s);
    endfunction

    function automatic trit_t t_mul(trit_t a, trit_t b);
        int s;
        s = (int'(a) * int'(b)) % 3;
        return trit_t'(s);
    endfunction

    // x * a mod f, using x^M = 2x^K + 1
    function automatic elem_t mulx(elem_t a);
        elem_t r;
        trit_t top;
        top = a[W-1 -: 2];
        r = {a[W-3:0], 2'b00};
        r[1:0] = top;
        r[2*K +: 2] = t_add(r[2*K +: 2], t_mul(2'd2, top));
        return r;
    endfunction
endpackage

// File: rtl/gf3m_ppg.sv
// Partial-product generator: scales every trit of an element by one digit.
// Assumes dig uses the 00/01/10 code.
module gf3m_ppg
    import gf3m_pkg::*;
(
    input  trit_t dig,
    input  elem_t a,
    output elem_t y
);
    for (genvar g = 0; g < M; g++) begin : g_trit
        // one GF(3) product per coefficient
        assign y[2*g +: 2] = t_mul(dig, a[2*g +: 2]);
    end
endmodule

// File: rtl/gf3m_sum.sv
// Multi-operand adder over GF(3^m): coefficient-wise sum of N elements.
module gf3m_sum
    import gf3m_pkg::*;
#(
    parameter int N = 4
) (
    input  elem_t ops [N],
    output elem_t y
);
    // accumulate all operands trit by trit
    always_comb begin
        y = '0;
        for (int k = 0; k < N; k++)
            for (int g = 0; g < M; g++)
                y[2*g +: 2] = t_add(y[2*g +: 2], ops[k][2*g +: 2]);
    end
endmodule

// File: rtl/gf3m_cuber.sv
// Cubing network: spreads trit i to exponent 3i, then folds the high
// exponents down with x^M = 2x^K + 1. All positions are fixed wiring plus
// small adders; nothing is stored.
module gf3m_cuber
    import gf3m_pkg::*;
(
    input  elem_t a,
    output elem_t y
);
    localparam int SPAN = 3 * M - 2;

    // spread, then fold from the top exponent downwards
    always_comb begin
        trit_t c [SPAN];
        for (int j = 0; j < SPAN; j++) c[j] = 2'b00;
        for (int i = 0; i < M; i++) c[3*i] = a[2*i +: 2];
        for (int j = SPAN - 1; j >= M; j--) begin
            c[j-M]   = t_add(c[j-M], c[j]);
            c[j-M+K] = t_add(c[j-M+K], t_mul(2'd2, c[j]));
            c[j]     = 2'b00;
        end
        for (int i = 0; i < M; i++) y[2*i +: 2] = c[i];
    end
endmodule

// File: rtl/gf3m_unified_op.sv
// Unified GF(3^97) operator: add, digit-serial multiply (D trits/cycle),
// cube. Ctl register shifts the multiplier out top-first; its trits 0/1 are
// add/cube weights. Assumes operands are loaded before start and that the
// multiplier's trits above M-1 are zero.
module gf3m_unified_op
    import gf3m_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_ctl,
    input  logic          ld_opa,
    input  logic          ld_opb,
    input  logic [CW-1:0] din_ctl,
    input  logic [W-1:0]  din_opa,
    input  logic [W-1:0]  din_opb,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic          chain,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  result
);
    logic [CW-1:0] ctl_q;
    elem_t         opa_q, opb_q, acc_q, cube_y, sum_y, acc_term;
    logic [NW-1:0] step_q;
    elem_t         ppg_in [D];
    trit_t         dig    [D];
    elem_t         sum_ops [D+1];
    elem_t         xpow   [D];
    op_e           op_s;

    assign op_s = op_e'(op);

    gf3m_cuber u_cuber (.a(opa_q), .y(cube_y));

    // select PPG inputs and digits for the active mode
    always_comb begin
        xpow[0] = opa_q;
        for (int g = 1; g < D; g++) xpow[g] = mulx(xpow[g-1]);
        acc_term = acc_q;
        for (int g = 0; g < D; g++) acc_term = mulx(acc_term);
        for (int g = 0; g < D; g++) begin
            ppg_in[g] = xpow[g];
            dig[g]    = 2'b00;
        end
        ppg_in[0] = opb_q;
        if (busy) begin
            for (int g = 0; g < D; g++) dig[g] = ctl_q[CW-2*D+2*g +: 2];
        end else begin
            acc_term = '0;
            case (op_s)
                OP_ADD: begin
                    ppg_in[1] = opa_q;
                    dig[0]    = ctl_q[1:0];
                    dig[1]    = ctl_q[3:2];
                end
                OP_CUBE: begin
                    ppg_in[0] = cube_y;
                    dig[0]    = ctl_q[1:0];
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < D; g++) begin : g_ppg
        gf3m_ppg u_ppg (.dig(dig[g]), .a(ppg_in[g]), .y(sum_ops[g]));
    end
    assign sum_ops[D] = acc_term;

    gf3m_sum #(.N(D+1)) u_sum (.ops(sum_ops), .y(sum_y));

    // registers: operand loads, step sequencing, accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            opa_q  <= '0;
            opb_q  <= '0;
            acc_q  <= '0;
            step_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                acc_q  <= sum_y;
                ctl_q  <= {ctl_q[CW-2*D-1:0], {(2*D){1'b0}}};
                step_q <= step_q + 1'b1;
                if (step_q == NW'(STEPS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else begin
                if (ld_ctl) ctl_q <= din_ctl;
                if (ld_opa) opa_q <= din_opa;
                if (ld_opb) opb_q <= din_opb;
                if (start) begin
                    case (op_s)
                        OP_ADD: begin
                            acc_q <= sum_y;
                            done  <= 1'b1;
                        end
                        OP_MUL: begin
                            acc_q  <= '0;
                            step_q <= '0;
                            busy   <= 1'b1;
                        end
                        OP_CUBE: begin
                            acc_q <= sum_y;
                            done  <= 1'b1;
                            if (chain) begin
                                opa_q <= sum_y;
                                opb_q <= sum_y;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign result = acc_q;

    // ---------------- assertions ----------------
    logic bad_code;
    // flag any trit of the accumulator holding the unused code
    always_comb begin
        bad_code = 1'b0;
        for (int g = 0; g < M; g++) bad_code |= &acc_q[2*g +: 2];
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !busy && !done));
    p_trit_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_code);
    p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (op_s == OP_ADD || op_s == OP_CUBE)) |=> (done && !busy));
    p_mul_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_s == OP_MUL) |=> (busy && !done));
    p_mul_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    p_hold_ops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(opa_q) && $stable(opb_q)));
    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_s == OP_RSV) |=> (!done && !busy && $stable(result)));
endmodule

// File: tb/gf3m_unified_op_bench.sv
`timescale 1ns/1ps
module gf3m_unified_op_bench;
    localparam int M  = 97;
    localparam int W  = 2 * M;
    localparam int CW = 198;
    typedef logic [W-1:0] el_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_ctl = 0, ld_opa = 0, ld_opb = 0;
    logic [CW-1:0] din_ctl = '0;
    el_t           din_opa = '0, din_opb = '0;
    logic          start = 0, chain = 0;
    logic [1:0]    op = 0;
    logic          busy, done;
    el_t           result;

    int nchk = 0, nfail = 0;

    always #2 clk = ~clk;   // 250 MHz

    gf3m_unified_op u_gf3m_unified_op (
        .clk(clk), .rst_n(rst_n), .ld_ctl(ld_ctl), .ld_opa(ld_opa),
        .ld_opb(ld_opb), .din_ctl(din_ctl), .din_opa(din_opa),
        .din_opb(din_opb), .start(start), .op(op), .chain(chain),
        .busy(busy), .done(done), .result(result));

    // ---------------- reference model ----------------
    function automatic el_t gen(int unsigned seed);
        el_t v = '0;
        int unsigned s = seed * 32'd2654435761 + 32'd7;
        for (int i = 0; i < M; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            v[2*i +: 2] = 2'((s >> 16) % 3);
        end
        return v;
    endfunction

    function automatic el_t rmul(el_t a, el_t b);
        int c [2*M-1];
        el_t v = '0;
        for (int k = 0; k < 2*M-1; k++) c[k] = 0;
        for (int i = 0; i < M; i++)
            for (int j = 0; j < M; j++)
                c[i+j] = (c[i+j] + int'(a[2*i +: 2]) * int'(b[2*j +: 2])) % 3;
        for (int k = 2*M-2; k >= M; k--) begin
            c[k-M]    = (c[k-M] + c[k]) % 3;
            c[k-M+12] = (c[k-M+12] + 2*c[k]) % 3;
            c[k] = 0;
        end
        for (int i = 0; i < M; i++) v[2*i +: 2] = 2'(c[i]);
        return v;
    endfunction

    function automatic el_t rlin(el_t a, int wa, el_t b, int wb);
        el_t v;
        for (int i = 0; i < M; i++)
            v[2*i +: 2] = 2'((wa * int'(a[2*i +: 2]) + wb * int'(b[2*i +: 2])) % 3);
        return v;
    endfunction

    function automatic bit clean(el_t v);
        for (int i = 0; i < M; i++) if (v[2*i +: 2] == 2'b11) return 1'b0;
        return 1'b1;
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input el_t act, input el_t exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input logic [CW-1:0] c, input el_t a, input el_t b,
                        input bit lc, input bit la, input bit lb);
        @(negedge clk);
        din_ctl = c; din_opa = a; din_opb = b;
        ld_ctl = lc; ld_opa = la; ld_opb = lb;
        @(negedge clk);
        ld_ctl = 0; ld_opa = 0; ld_opb = 0;
    endtask

    task automatic run(input logic [1:0] o, input bit ch, output int lat);
        @(negedge clk);
        start = 1; op = o; chain = ch;
        @(negedge clk);
        start = 0; chain = 0;
        lat = 0;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [CW-1:0] ctlw(int c0, int c1);
        logic [CW-1:0] v = '0;
        v[1:0] = 2'(c0);
        v[3:2] = 2'(c1);
        return v;
    endfunction

    // stimulus table: op, seed a, seed b, weight c0, weight c1
    typedef struct packed {
        logic [1:0]  o;
        logic [15:0] sa;
        logic [15:0] sb;
        logic [1:0]  c0;
        logic [1:0]  c1;
    } vec_t;
    localparam vec_t VECS [8] = '{
        '{2'd0, 16'd11, 16'd12, 2'd1, 2'd1},
        '{2'd0, 16'd13, 16'd14, 2'd2, 2'd1},
        '{2'd0, 16'd15, 16'd16, 2'd2, 2'd2},
        '{2'd1, 16'd21, 16'd22, 2'd0, 2'd0},
        '{2'd1, 16'd23, 16'd24, 2'd0, 2'd0},
        '{2'd1, 16'd25, 16'd26, 2'd0, 2'd0},
        '{2'd2, 16'd31, 16'd0,  2'd1, 2'd0},
        '{2'd2, 16'd32, 16'd0,  2'd2, 2'd0}
    };

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int lat;
        el_t a, b, exp, x96, x2, saved;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(result == '0 && !busy && !done, "R1 reset state", result, '0);

        // table walk: R3 add, R4 multiply, R6 cube, R2 trit codes
        for (int v = 0; v < 8; v++) begin
            a = gen(VECS[v].sa);
            b = gen(VECS[v].sb);
            if (VECS[v].o == 2'd0) begin
                load(ctlw(VECS[v].c0, VECS[v].c1), a, b, 1, 1, 1);
                exp = rlin(b, VECS[v].c0, a, VECS[v].c1);
                run(2'd0, 0, lat);
                check(result == exp, "R3 add", result, exp);
                check_int("R3 add latency", lat, 0);
            end else if (VECS[v].o == 2'd1) begin
                load({4'b0, a}, b, b, 1, 1, 1);
                exp = rmul(a, b);
                run(2'd1, 0, lat);
                check(result == exp, "R4 product", result, exp);
                check_int("R4 product latency", lat, 33);
            end else begin
                load(ctlw(VECS[v].c0, 0), a, a, 1, 1, 1);
                exp = rlin(rmul(a, rmul(a, a)), VECS[v].c0, a, 0);
                run(2'd2, 0, lat);
                check(result == exp, "R6 cube", result, exp);
                check_int("R6 cube latency", lat, 0);
            end
            check(clean(result), "R2 trit code", result, '0);
        end

        // R5: x^96 * x^2 = x + 2x^13
        x96 = '0; x96[2*96 +: 2] = 2'd1;
        x2  = '0; x2[2*2 +: 2]   = 2'd1;
        exp = '0; exp[2*1 +: 2] = 2'd1; exp[2*13 +: 2] = 2'd2;
        load({4'b0, x96}, x2, x2, 1, 1, 1);
        run(2'd1, 0, lat);
        check(result == exp, "R5 reduction wrap", result, exp);

        // R4: multiplying by the constant 1 returns b
        b = gen(77);
        load({{(CW-2){1'b0}}, 2'd1}, b, b, 1, 1, 1);
        run(2'd1, 0, lat);
        check(result == b, "R4 unit multiplier", result, b);

        // R7: chained cubes give a^9
        a = gen(55);
        load(ctlw(1, 0), a, a, 1, 1, 1);
        run(2'd2, 1, lat);
        exp = rmul(a, rmul(a, a));
        check(result == exp, "R7 first chained cube", result, exp);
        run(2'd2, 1, lat);
        exp = rmul(exp, rmul(exp, exp));
        check(result == exp, "R7 second chained cube a^9", result, exp);

        // R8: loads and start while busy have no effect
        a = gen(91); b = gen(92);
        load({4'b0, a}, b, b, 1, 1, 1);
        @(negedge clk);
        start = 1; op = 2'd1;
        @(negedge clk);
        start = 1; op = 2'd0; ld_opa = 1; ld_opb = 1; din_opa = gen(93); din_opb = gen(94);
        @(negedge clk);
        start = 0; ld_opa = 0; ld_opb = 0;
        lat = 1;
        while (!done && lat < 60) begin @(negedge clk); lat++; end
        exp = rmul(a, b);
        check(result == exp, "R8 product undisturbed", result, exp);
        check_int("R8 latency unchanged", lat, 33);
        load(ctlw(0, 1), '0, '0, 1, 0, 0);
        run(2'd0, 0, lat);
        check(result == b, "R8 operand A retained", result, b);

        // R9: reserved op does nothing
        saved = result;
        run(2'd3, 0, lat);
        check_int("R9 no done", lat, 60);
        check(result == saved && !busy, "R9 result kept", result, saved);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule